// File: doc/BRIEF.md
# Serial Port Master for an Eight-Channel 14-bit ADC

This block sits on the FPGA side of a 14-bit, eight-channel successive-approximation converter. The converter talks through a 16-bit framed serial port. A host hands the block a 4-bit command through a valid/ready handshake. The configuration-write command also carries 12 bits of payload. The block then runs one frame: it lowers chip select with frame sync held high, and it generates the serial clock from the system clock through a programmable half-period divider. It shifts the command word out MSB first and shifts the converter's reply in, and at the end it reports the 14-bit result of the previous conversion with a one-cycle done pulse.

A command can also ask for an external conversion-start strobe. The block issues the strobe only after the eleventh rising serial-clock edge of the frame. The strobe's low time (sampling) and high time (conversion) come from cycle-count inputs. The converter's end-of-conversion/interrupt line is synchronized. Its falling edge sets a sticky data-ready flag. The flag clears at the block's next chip-select fall or conversion-start fall.

Top module: `adc_port_master`

## Requirements
- R1: After reset, adcCsN, adcSclk, adcFs and adcCstartN are high, adcSdi is 0, cmdReady is 1, rspDone and dataReady are 0.
- R2: An accepted command produces one frame in which adcCsN stays low for exactly 16 falling adcSclk edges. adcSclk is high whenever adcCsN is high.
- R3: The word on adcSdi is {cmdOp, payload}, sent MSB first and valid at every falling adcSclk edge, the first bit included. The payload is cmdData when cmdOp is 4'hA (configuration write) and zero for any other opcode.
- R4: adcSdo is sampled at each falling adcSclk edge. After the frame, rspResult holds the first 14 sampled bits (first bit as bit 13), the last two are dropped, and rspDone pulses high for exactly one cycle.
- R5: For opcode 4'hA the reply is discarded: rspResult keeps its previous value while rspDone still pulses.
- R6: Every adcSclk low and high phase inside a frame, including the time from the adcCsN fall to the first adcSclk fall, lasts max(cfgHalfDiv,1) system clocks.
- R7: A command accepted with cmdStart=1 produces exactly one low pulse on adcCstartN lasting max(cfgStartLow,1) clocks. It is followed by at least max(cfgStartHigh,1) high clocks before cmdReady returns.
- R8: adcCstartN never falls before the 11th rising adcSclk edge of the frame of the command that requested it.
- R9: A falling edge on adcIntN sets dataReady within four clocks. dataReady is cleared by the block's next adcCsN fall or adcCstartN fall.
- R10: cmdReady is 0 from the accepting edge until the frame and any strobe pulse have ended. A cmdValid while cmdReady is 0 starts no frame.
- R11: adcFs is held high at all times, so every frame is started by the chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block can accept a command |
| cmdOp | input | 4 | Command opcode (4'hA = configuration write) |
| cmdData | input | 12 | Payload for configuration write |
| cmdStart | input | 1 | Issue a conversion-start strobe in this frame |
| cfgHalfDiv | input | 8 | Serial clock half period in system clocks |
| cfgStartLow | input | 8 | Strobe low time in system clocks |
| cfgStartHigh | input | 8 | Strobe high time in system clocks |
| rspResult | output | 14 | Result of the previous conversion |
| rspDone | output | 1 | One-cycle frame-complete pulse |
| dataReady | output | 1 | Sticky data-ready flag |
| adcCsN | output | 1 | Chip select, active low |
| adcFs | output | 1 | Frame sync, held high |
| adcSclk | output | 1 | Serial clock |
| adcSdi | output | 1 | Serial data to converter |
| adcSdo | input | 1 | Serial data from converter |
| adcCstartN | output | 1 | Conversion-start strobe |
| adcIntN | input | 1 | End-of-conversion / interrupt |

## Verification
The bench builds the block with its default widths: an 8-bit divider, 8-bit strobe counters and a two-stage interrupt synchronizer. It changes cfgHalfDiv between 1 and 4 from frame to frame, so the exact half-period check covers both the single-cycle divider and longer phases. Strobe low and high times from 1 to 5 let pulses either end inside the frame or run past chip select. This shows that cmdReady waits for the strobe and not only for the frame.

// File: rtl/adcp_pkg.sv
package adcp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_LOW,
    PH_HIGH,
    PH_TAIL,
    PH_DONE
  } frame_phase_e;

  typedef enum logic [1:0] {
    SP_IDLE,
    SP_LOW,
    SP_HIGH
  } strobe_phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture command word
    logic shift;     // advance transmit word
    logic sample;    // capture one reply bit
    logic commit;    // frame finished
    logic irqClear;  // chip-select or strobe fall issued
  } ctrl_strobe_t;

endpackage

// File: rtl/adcp_ctrl.sv
module adcp_ctrl
  import adcp_pkg::*;
#(
  parameter int WORD_W        = 16,
  parameter int HALF_W        = 8,
  parameter int START_W       = 8,
  parameter int START_MIN_RISE = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic               cmdStart,
  input  logic [HALF_W-1:0]  cfgHalfDiv,
  input  logic [START_W-1:0] cfgStartLow,
  input  logic [START_W-1:0] cfgStartHigh,
  output logic               cmdReady,
  output logic               csN,
  output logic               sclk,
  output logic               cstartN,
  output ctrl_strobe_t       strb
);

  localparam int BIT_W  = $clog2(WORD_W);
  localparam int RISE_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [RISE_W-1:0] RISE_MAX = RISE_W'(WORD_W);
  localparam logic [RISE_W-1:0] RISE_GATE = RISE_W'(START_MIN_RISE);

  frame_phase_e  phase;
  strobe_phase_e sPhase;
  logic [HALF_W-1:0]  divCnt;
  logic [HALF_W-1:0]  halfLim;
  logic [BIT_W-1:0]   bitCnt;
  logic [RISE_W-1:0]  riseCnt;
  logic [START_W-1:0] sCnt;
  logic [START_W-1:0] lowLim;
  logic [START_W-1:0] highLim;
  logic startPend;
  logic divEnd;
  logic accept;
  logic trigger;

  assign halfLim = (cfgHalfDiv == '0) ? HALF_W'(1) : cfgHalfDiv;
  assign lowLim  = (cfgStartLow == '0) ? START_W'(1) : cfgStartLow;
  assign highLim = (cfgStartHigh == '0) ? START_W'(1) : cfgStartHigh;
  assign divEnd  = (divCnt == halfLim - HALF_W'(1));

  assign cmdReady = (phase == PH_IDLE) && (sPhase == SP_IDLE) && !startPend;
  assign accept   = cmdValid && cmdReady;
  assign trigger  = startPend && (sPhase == SP_IDLE) && (riseCnt >= RISE_GATE);

  always_comb begin
    strb          = '0;
    strb.load     = accept;
    strb.sample   = ((phase == PH_LEAD) || (phase == PH_HIGH)) && divEnd;
    strb.shift    = (phase == PH_LOW) && divEnd && (bitCnt != LAST_BIT);
    strb.commit   = (phase == PH_DONE);
    strb.irqClear = accept || trigger;
  end

  // Frame sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      riseCnt <= '0;
      csN     <= 1'b1;
      sclk    <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          divCnt <= '0;
          if (accept) begin
            csN     <= 1'b0;
            bitCnt  <= '0;
            riseCnt <= '0;
            phase   <= PH_LEAD;
          end
        end
        PH_LEAD, PH_HIGH: begin
          if (divEnd) begin
            divCnt <= '0;
            sclk   <= 1'b0;
            phase  <= PH_LOW;
          end else begin
            divCnt <= divCnt + HALF_W'(1);
          end
        end
        PH_LOW: begin
          if (divEnd) begin
            divCnt <= '0;
            sclk   <= 1'b1;
            if (riseCnt != RISE_MAX) riseCnt <= riseCnt + RISE_W'(1);
            if (bitCnt == LAST_BIT) begin
              phase <= PH_TAIL;
            end else begin
              bitCnt <= bitCnt + BIT_W'(1);
              phase  <= PH_HIGH;
            end
          end else begin
            divCnt <= divCnt + HALF_W'(1);
          end
        end
        PH_TAIL: begin
          if (divEnd) begin
            divCnt <= '0;
            csN    <= 1'b1;
            phase  <= PH_DONE;
          end else begin
            divCnt <= divCnt + HALF_W'(1);
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Conversion-start strobe engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sPhase    <= SP_IDLE;
      sCnt      <= '0;
      cstartN   <= 1'b1;
      startPend <= 1'b0;
    end else begin
      if (accept) startPend <= cmdStart;
      else if (trigger) startPend <= 1'b0;
      unique case (sPhase)
        SP_IDLE: begin
          sCnt <= '0;
          if (trigger) begin
            cstartN <= 1'b0;
            sPhase  <= SP_LOW;
          end
        end
        SP_LOW: begin
          if (sCnt == lowLim - START_W'(1)) begin
            sCnt    <= '0;
            cstartN <= 1'b1;
            sPhase  <= SP_HIGH;
          end else begin
            sCnt <= sCnt + START_W'(1);
          end
        end
        SP_HIGH: begin
          if (sCnt >= highLim - START_W'(1)) begin
            sCnt   <= '0;
            sPhase <= SP_IDLE;
          end else begin
            sCnt <= sCnt + START_W'(1);
          end
        end
        default: sPhase <= SP_IDLE;
      endcase
    end
  end

  // R2: serial clock parked high outside a frame
  p_sclk_parked_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  // R2: chip select releases only after the last bit
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (bitCnt == LAST_BIT));

  // R10: no new command while the frame runs
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !cmdReady);

  // R8: strobe gated by the rising-edge count
  p_start_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cstartN) |-> (riseCnt >= RISE_GATE));

  // R7: strobe low only while its engine is in the low phase
  p_strobe_phase_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cstartN |-> (sPhase == SP_LOW));

endmodule

// File: rtl/adcp_dpath.sv
module adcp_dpath
  import adcp_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CMD_W    = 4,
  parameter int RES_W    = 14,
  parameter int SYNC_LEN = 2,
  parameter logic [CMD_W-1:0] WRITE_OP = 4'hA
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobe_t              strb,
  input  logic [CMD_W-1:0]          cmdOp,
  input  logic [WORD_W-CMD_W-1:0]   cmdData,
  input  logic                      sdo,
  input  logic                      intN,
  output logic                      sdi,
  output logic [RES_W-1:0]          result,
  output logic                      done,
  output logic                      dataReady
);

  localparam int DATA_W = WORD_W - CMD_W;

  logic [WORD_W-1:0]   txWord;
  logic [WORD_W-1:0]   rxWord;
  logic                isWrite;
  logic [SYNC_LEN-1:0] syncChain;
  logic                intLevel;
  logic                intPrev;
  logic                intFall;

  assign sdi = txWord[WORD_W-1];

  // Transmit and receive shifters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord  <= '0;
      rxWord  <= '0;
      isWrite <= 1'b0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.commit;
      if (strb.load) begin
        isWrite <= (cmdOp == WRITE_OP);
        txWord  <= {cmdOp, (cmdOp == WRITE_OP) ? cmdData : DATA_W'(0)};
      end else if (strb.shift) begin
        txWord <= {txWord[WORD_W-2:0], 1'b0};
      end
      if (strb.sample) rxWord <= {rxWord[WORD_W-2:0], sdo};
      if (strb.commit && !isWrite) result <= rxWord[WORD_W-1 -: RES_W];
    end
  end

  // Interrupt synchronizer
  generate
    if (SYNC_LEN == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= intN;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_LEN-2:0], intN};
      end
    end
  endgenerate

  assign intLevel = syncChain[SYNC_LEN-1];
  assign intFall  = intPrev && !intLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intPrev   <= 1'b1;
      dataReady <= 1'b0;
    end else begin
      intPrev <= intLevel;
      if (intFall)            dataReady <= 1'b1;
      else if (strb.irqClear) dataReady <= 1'b0;
    end
  end

  // R5: a configuration write leaves the result alone
  p_write_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && isWrite) |=> $stable(result));

  // R4: done lasts a single cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: synchronized interrupt edge raises the flag
  p_irq_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    intFall |=> dataReady);

  // R9: a clear without a new edge drops the flag
  p_irq_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.irqClear && !intFall) |=> !dataReady);

endmodule

// File: rtl/adc_port_master.sv
module adc_port_master
  import adcp_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CMD_W    = 4,
  parameter int RES_W    = 14,
  parameter int HALF_W   = 8,
  parameter int START_W  = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  output logic                    cmdReady,
  input  logic [CMD_W-1:0]        cmdOp,
  input  logic [WORD_W-CMD_W-1:0] cmdData,
  input  logic                    cmdStart,
  input  logic [HALF_W-1:0]       cfgHalfDiv,
  input  logic [START_W-1:0]      cfgStartLow,
  input  logic [START_W-1:0]      cfgStartHigh,
  output logic [RES_W-1:0]        rspResult,
  output logic                    rspDone,
  output logic                    dataReady,
  output logic                    adcCsN,
  output logic                    adcFs,
  output logic                    adcSclk,
  output logic                    adcSdi,
  input  logic                    adcSdo,
  output logic                    adcCstartN,
  input  logic                    adcIntN
);

  ctrl_strobe_t strb;

  // Frames are always opened by chip select
  assign adcFs = 1'b1;

  adcp_ctrl #(
    .WORD_W(WORD_W), .HALF_W(HALF_W), .START_W(START_W), .START_MIN_RISE(11)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdStart(cmdStart),
    .cfgHalfDiv(cfgHalfDiv), .cfgStartLow(cfgStartLow),
    .cfgStartHigh(cfgStartHigh), .cmdReady(cmdReady), .csN(adcCsN),
    .sclk(adcSclk), .cstartN(adcCstartN), .strb(strb)
  );

  adcp_dpath #(
    .WORD_W(WORD_W), .CMD_W(CMD_W), .RES_W(RES_W), .SYNC_LEN(SYNC_LEN),
    .WRITE_OP(CMD_W'(4'hA))
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdOp(cmdOp), .cmdData(cmdData),
    .sdo(adcSdo), .intN(adcIntN), .sdi(adcSdi), .result(rspResult),
    .done(rspDone), .dataReady(dataReady)
  );

  // R11: frame sync never moves
  p_fs_high_r11: assert property (@(posedge clk) disable iff (!rstN)
    adcFs);

endmodule

// File: tb/sim_adc_port_master.sv
`timescale 1ns/1ps
module sim_adc_port_master;

  localparam realtime PER = 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] cmdOp = '0;
  logic [11:0] cmdData = '0;
  logic cmdStart = 1'b0;
  logic [7:0] cfgHalfDiv = 8'd2;
  logic [7:0] cfgStartLow = 8'd2;
  logic [7:0] cfgStartHigh = 8'd2;
  logic cmdReady, rspDone, dataReady;
  logic [13:0] rspResult;
  logic adcCsN, adcFs, adcSclk, adcSdi, adcCstartN;
  logic adcSdo = 1'b0;
  logic adcIntN = 1'b1;

  int total = 0;
  int fails = 0;

  // slave-model state
  logic [15:0] sdoWord = '0;
  logic [15:0] rxWord = '0;
  int sdoIdx = 0;
  int fallCnt = 0;
  int riseCntB = 0;
  int frames = 0;
  int hpBad = 0;
  int hdEff = 2;
  realtime tEdge = 0.0;
  int startSeen = 0;
  int startEarly = 0;
  int widthBad = 0;
  int lowEff = 2;
  int highEff = 2;
  realtime tcsFall = 0.0;
  realtime tcsRise = 0.0;
  logic [13:0] expRes = '0;

  always #(PER/2.0) clk = ~clk;

  adc_port_master u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdData(cmdData), .cmdStart(cmdStart),
    .cfgHalfDiv(cfgHalfDiv), .cfgStartLow(cfgStartLow),
    .cfgStartHigh(cfgStartHigh), .rspResult(rspResult), .rspDone(rspDone),
    .dataReady(dataReady), .adcCsN(adcCsN), .adcFs(adcFs),
    .adcSclk(adcSclk), .adcSdi(adcSdi), .adcSdo(adcSdo),
    .adcCstartN(adcCstartN), .adcIntN(adcIntN)
  );

  function automatic bit nearT(realtime a, realtime b);
    return (a - b < 0.1) && (b - a < 0.1);
  endfunction

  function automatic logic [15:0] expectWord(logic [3:0] op, logic [11:0] d);
    return {op, (op == 4'hA) ? d : 12'h000};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  always @(negedge adcCsN) begin
    sdoWord  = 16'($urandom);
    adcSdo   = sdoWord[15];
    sdoIdx   = 14;
    fallCnt  = 0;
    riseCntB = 0;
    rxWord   = '0;
    hpBad    = 0;
    frames++;
    tEdge    = $realtime;
  end

  always @(posedge adcSclk) if (!adcCsN) begin
    riseCntB++;
    if (!nearT($realtime - tEdge, hdEff * PER)) hpBad++;
    tEdge = $realtime;
    if (sdoIdx >= 0) begin
      adcSdo = sdoWord[sdoIdx];
      sdoIdx--;
    end
  end

  always @(negedge adcSclk) if (!adcCsN) begin
    fallCnt++;
    rxWord = {rxWord[14:0], adcSdi};
    if (!nearT($realtime - tEdge, hdEff * PER)) hpBad++;
    tEdge = $realtime;
  end

  always @(negedge adcCstartN) if (rstN) begin
    startSeen++;
    if (riseCntB < 11) startEarly++;
    tcsFall = $realtime;
  end

  always @(posedge adcCstartN) if (rstN) begin
    if (!nearT($realtime - tcsFall, lowEff * PER)) widthBad++;
    tcsRise = $realtime;
  end

  task automatic runCmd(input logic [3:0] op, input logic [11:0] d, input bit st,
                        input int hd, input int lo, input int hi);
    int s0;
    int f0;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cfgHalfDiv   = 8'(hd);
    cfgStartLow  = 8'(lo);
    cfgStartHigh = 8'(hi);
    hdEff   = (hd == 0) ? 1 : hd;
    lowEff  = (lo == 0) ? 1 : lo;
    highEff = (hi == 0) ? 1 : hi;
    s0 = startSeen;
    f0 = frames;
    cmdOp = op; cmdData = d; cmdStart = st; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(!cmdReady, "R10 ready low after accept", 32'(cmdReady), 0);
    while (!rspDone) @(negedge clk);
    chk(frames == f0 + 1, "R2 one frame", 32'(frames), 32'(f0 + 1));
    chk(fallCnt == 16, "R2 falling edges", 32'(fallCnt), 16);
    chk(rxWord == expectWord(op, d), "R3 sdi word", 32'(rxWord),
        32'(expectWord(op, d)));
    chk(hpBad == 0, "R6 half period", 32'(hpBad), 0);
    if (op != 4'hA) begin
      expRes = sdoWord[15:2];
      chk(rspResult == expRes, "R4 result", 32'(rspResult), 32'(expRes));
    end else begin
      chk(rspResult == expRes, "R5 write keeps result", 32'(rspResult),
          32'(expRes));
    end
    @(negedge clk);
    chk(!rspDone, "R4 done single", 32'(rspDone), 0);
    chk(adcFs, "R11 fs high", 32'(adcFs), 1);
    if (st) begin
      while (!cmdReady) @(negedge clk);
      chk(startSeen == s0 + 1, "R7 one strobe", 32'(startSeen), 32'(s0 + 1));
      chk(startEarly == 0, "R8 strobe after 11th rise", 32'(startEarly), 0);
      chk(widthBad == 0, "R7 low width", 32'(widthBad), 0);
      chk(($realtime - tcsRise) > (highEff * PER - 0.1), "R7 high time",
          32'(int'(($realtime - tcsRise) / PER)), 32'(highEff));
    end else begin
      chk(startSeen == s0, "R7 no strobe", 32'(startSeen), 32'(s0));
    end
  endtask

  initial begin
    #(200000 * PER);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_a11c));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(adcCsN && adcSclk && adcFs && adcCstartN && !adcSdi && cmdReady &&
        !rspDone && !dataReady, "R1 reset state",
        32'({adcCsN, adcSclk, adcFs, adcCstartN, adcSdi, cmdReady, rspDone, dataReady}),
        32'b11110100);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runCmd(4'h1, 12'hFFF, 1'b0, 2, 2, 2);          // payload zeroed (R3)
    runCmd(4'hA, 12'h5A3, 1'b0, 1, 1, 1);          // R5 write, fastest clock
    runCmd(4'h3, 12'h000, 1'b1, 0, 0, 0);          // zero settings act as 1 (R6, R7)
    runCmd(4'hA, 12'hC3C, 1'b1, 4, 5, 5);          // write with strobe

    // R10: valid while busy starts nothing
    begin
      int f0;
      @(negedge clk);
      while (!cmdReady) @(negedge clk);
      f0 = frames;
      cmdOp = 4'h2; cmdData = '0; cmdStart = 1'b0; cmdValid = 1'b1;
      hdEff = 2; cfgHalfDiv = 8'd2;
      @(negedge clk);
      cmdValid = 1'b0;
      repeat (5) @(negedge clk);
      cmdOp = 4'h7; cmdValid = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0;
      while (!rspDone) @(negedge clk);
      expRes = sdoWord[15:2];
      repeat (6) @(negedge clk);
      chk(frames == f0 + 1, "R10 busy valid ignored", 32'(frames), 32'(f0 + 1));
    end

    // R9 interrupt flag
    @(negedge clk);
    chk(!dataReady, "R9 flag idle", 32'(dataReady), 0);
    adcIntN = 1'b0;
    repeat (4) @(negedge clk);
    chk(dataReady, "R9 set on falling edge", 32'(dataReady), 1);
    adcIntN = 1'b1;
    repeat (4) @(negedge clk);
    chk(dataReady, "R9 sticky", 32'(dataReady), 1);
    runCmd(4'h4, 12'h000, 1'b0, 2, 2, 2);
    chk(!dataReady, "R9 cleared by chip select", 32'(dataReady), 0);
    // clear by strobe fall: set flag mid-frame after chip select fell
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cfgHalfDiv = 8'd3; hdEff = 3; cfgStartLow = 8'd3; lowEff = 3;
    cfgStartHigh = 8'd2; highEff = 2;
    cmdOp = 4'h5; cmdStart = 1'b1; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (8) @(negedge clk);
    adcIntN = 1'b0;
    repeat (4) @(negedge clk);
    adcIntN = 1'b1;
    chk(dataReady, "R9 set mid-frame", 32'(dataReady), 1);
    while (adcCstartN) @(negedge clk);
    @(negedge clk);
    chk(!dataReady, "R9 cleared by strobe fall", 32'(dataReady), 0);
    while (!rspDone) @(negedge clk);
    expRes = sdoWord[15:2];
    chk(rspResult == expRes, "R4 result with strobe", 32'(rspResult), 32'(expRes));

    // constrained random commands
    for (int i = 0; i < 40; i++) begin
      logic [3:0] op;
      op = ($urandom_range(0, 3) == 0) ? 4'hA : 4'($urandom);
      runCmd(op, 12'($urandom), 1'($urandom), $urandom_range(1, 4),
             $urandom_range(1, 5), $urandom_range(1, 5));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule